// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

This block is a 16-bit timer-counter with two operating modes that share one interrupt request. It counts either a prescaled internal tick, one every six clocks, or falling edges on a counter input pin. Counting happens only while a run bit is set. In capture mode a falling edge on the external pin copies the running count into a 16-bit capture register, and counting carries on without any reload. In reload mode the same register holds the value that the counter reloads from. The counter counts up, or, when the down-count enable bit is set, up or down as the external pin level selects.

Software reaches the block through a small byte-wide register port with five addresses. Address 0 holds the control byte. Its bits are: run (bit 0), source select (bit 1, 1 = counter pin), mode (bit 2, 1 = reload), external enable (bit 3), down-count enable (bit 4), the external flag EXF (bit 6) and the overflow flag TF (bit 7). Bit 5 always reads 0. The count bytes sit at address 1 (low) and address 2 (high). The capture/reload bytes sit at address 3 (low) and address 4 (high). Both pins pass through a two-flop synchronizer before falling-edge detection, so a count or capture takes effect on the third clock edge after the pin falls.

Top module: `tmr16_capreload`

## Requirements
- R1: After reset, all five registers read 0 and irq is low.
- R2: With bit 0 set, the count increments once every 6 clocks when bit 1 = 0, and once per falling edge of cnt_pin when bit 1 = 1.
- R3: With bit 0 clear, neither the prescaled tick nor cnt_pin edges change the count.
- R4: In capture mode (bit 2 = 0, bit 3 = 1), a falling edge on ext_pin copies the count into addresses 3/4 and sets bit 6. The count keeps running without reload, and each later edge overwrites the capture value.
- R5: In capture mode, a step from 0xFFFF wraps the count to 0x0000 and sets bit 7.
- R6: In reload mode with bit 4 = 0, a step from 0xFFFF loads the count from addresses 3/4 and sets bit 7. Any other step adds 1.
- R7: In reload mode with bit 4 = 0 and bit 3 = 1, a falling edge on ext_pin loads the count from addresses 3/4 and sets bit 6. This happens even with bit 0 clear.
- R8: In reload mode with bit 4 = 1, a high synchronized ext_pin counts up and a low one counts down. Up from 0xFFFF reloads from addresses 3/4. Down at a count equal to the reload value loads 0xFFFF. Each such event sets bit 7 and toggles bit 6. An ext_pin edge neither captures nor reloads in this mode.
- R9: irq is high when bit 7 is set, or when bit 6 is set and the block is not in up/down operation (bit 2 = 1 and bit 4 = 1).
- R10: Bits 6 and 7 stay set until a write to address 0 clears them.
- R11: A write to a count byte in the same cycle as a count step wins. The written byte takes the new value and the other byte is kept unchanged.
- R12: Only falling edges count; a low-to-high transition on cnt_pin or ext_pin triggers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_pin | input | 1 | Counter input pin (asynchronous) |
| ext_pin | input | 1 | Capture trigger / reload trigger / direction pin (asynchronous) |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each pin holds its level for at least three clocks, so the synchronizer sees every falling edge as a single pulse. They also assume that software writes at most one register per cycle. The stimulus holds each pin low for four clocks and then high for four, and it writes registers one cycle at a time. Register writes that are meant to collide with a count step are placed on the exact cycle the step lands, and that cycle is derived from the synchronizer depth.

// File: rtl/tmr16_pkg.sv
// Shared constants and types for the capture/reload timer-counter.
// Assumes a 16-bit count exposed as two bytes.
package tmr16_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_CNT_LO = 3'd1,
        RA_CNT_HI = 3'd2,
        RA_CAP_LO = 3'd3,
        RA_CAP_HI = 3'd4
    } reg_addr_e;

    // Control byte, MSB first: tf is bit 7, run is bit 0.
    typedef struct packed {
        logic tf;
        logic exf;
        logic rsv;
        logic dn_en;
        logic ext_en;
        logic reload;
        logic src_pin;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/tmr16_sync_fall.sv
// Synchronizes an asynchronous pin through STAGES flops and flags
// falling edges of the synchronized level as a one-cycle pulse.
// Assumes the pin idles high; reset loads 1s so no false edge appears.
module tmr16_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic fall
);
    logic [STAGES-1:0] shift_q;
    logic              last_q;

    // Shift the pin into the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '1;
            last_q  <= 1'b1;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], pin};
            last_q  <= shift_q[STAGES-1];
        end
    end

    // Level output and 1-to-0 detection.
    always_comb begin
        lvl  = shift_q[STAGES-1];
        fall = last_q & ~shift_q[STAGES-1];
    end

    // R12
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tmr16_prescale.sv
// Free-running divider that emits one tick every DIV clocks.
// Assumes DIV >= 2.
module tmr16_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    // Tick on the last phase.
    always_comb tick = (div_q == LAST);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr16_core.sv
// Counter and capture/reload register datapath. Produces flag events for
// the control register; software byte writes override hardware updates.
// Assumes at most one byte write per cycle and a one-cycle tick.
module tmr16_core
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              reload_mode,
    input  logic              ext_en,
    input  logic              dn_en,
    input  logic              ext_lvl,
    input  logic              ext_fall,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic              wr_cap_lo,
    input  logic              wr_cap_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cap_q,
    output logic              tf_set,
    output logic              exf_set,
    output logic              exf_tog
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cap_d;
    logic             step;
    logic             ext_hit;

    // Next-state of count and capture register, then software override.
    always_comb begin
        step    = run & tick;
        ext_hit = ext_en & ext_fall;
        cnt_d   = cnt_q;
        cap_d   = cap_q;
        tf_set  = 1'b0;
        exf_set = 1'b0;
        exf_tog = 1'b0;
        if (!reload_mode) begin
            if (step) begin
                cnt_d  = cnt_q + ONE;
                tf_set = (cnt_q == MAXV);
            end
            if (ext_hit) begin
                cap_d   = cnt_q;
                exf_set = 1'b1;
            end
        end else if (!dn_en) begin
            if (ext_hit) begin
                cnt_d   = cap_q;
                exf_set = 1'b1;
            end else if (step) begin
                if (cnt_q == MAXV) begin
                    cnt_d  = cap_q;
                    tf_set = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
        end else if (step) begin
            if (ext_lvl) begin
                if (cnt_q == MAXV) begin
                    cnt_d   = cap_q;
                    tf_set  = 1'b1;
                    exf_tog = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == cap_q) begin
                    cnt_d   = MAXV;
                    tf_set  = 1'b1;
                    exf_tog = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
        if (wr_cnt_lo || wr_cnt_hi) begin
            cnt_d   = cnt_q;
            tf_set  = 1'b0;
            exf_tog = 1'b0;
            if (!reload_mode || dn_en) exf_set = exf_set;
            else                       exf_set = 1'b0;
            if (wr_cnt_lo) cnt_d[BYTE_W-1:0]     = wdata;
            if (wr_cnt_hi) cnt_d[CNT_W-1:BYTE_W] = wdata;
        end
        if (wr_cap_lo || wr_cap_hi) begin
            cap_d = cap_q;
            if (wr_cap_lo) cap_d[BYTE_W-1:0]     = wdata;
            if (wr_cap_hi) cap_d[CNT_W-1:BYTE_W] = wdata;
        end
    end

    // Register the count and the capture/reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            cap_q <= cap_d;
        end
    end

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ext_fall && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_q));

    // R4
    capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_mode && ext_en && ext_fall && !wr_cap_lo && !wr_cap_hi)
        |=> (cap_q == $past(cnt_q)));

    // R8
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_mode && dn_en && run && tick && !ext_lvl && (cnt_q != cap_q)
         && !wr_cnt_lo && !wr_cnt_hi) |=> (cnt_q == $past(cnt_q) - ONE));

    // R6
    up_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_mode && !dn_en && run && tick && !(ext_en && ext_fall)
         && (cnt_q == MAXV) && !wr_cnt_lo && !wr_cnt_hi)
        |=> (cnt_q == $past(cap_q)));
endmodule

// File: rtl/tmr16_capreload.sv
// Top of the capture/reload timer-counter: control register with sticky
// flags, register read mux, count source selection and pin conditioning.
// Assumes pins idle high and hold each level for at least three clocks.
module tmr16_capreload
    import tmr16_pkg::*;
#(
    parameter int PRESCALE    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_pin,
    input  logic              ext_pin,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq
);
    ctrl_t            ctrl_q;
    ctrl_t            wr_ctrl_v;
    logic             cnt_lvl, cnt_fall, ext_lvl, ext_fall;
    logic             pre_tick, tick;
    logic [CNT_W-1:0] cnt_q, cap_q;
    logic             tf_set, exf_set, exf_tog;
    logic             wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_cap_lo, wr_cap_hi;
    logic             exf_base, updown;

    tmr16_sync_fall #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .lvl(cnt_lvl), .fall(cnt_fall));

    tmr16_sync_fall #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .lvl(ext_lvl), .fall(ext_fall));

    tmr16_prescale #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick));

    // Address decode and count source selection.
    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
        wr_cnt_lo = reg_wr && (reg_addr == RA_CNT_LO);
        wr_cnt_hi = reg_wr && (reg_addr == RA_CNT_HI);
        wr_cap_lo = reg_wr && (reg_addr == RA_CAP_LO);
        wr_cap_hi = reg_wr && (reg_addr == RA_CAP_HI);
        wr_ctrl_v = ctrl_t'(reg_wdata);
        tick      = ctrl_q.src_pin ? cnt_fall : pre_tick;
        updown    = ctrl_q.reload & ctrl_q.dn_en;
    end

    tmr16_core u_core (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl_q.run), .tick(tick),
        .reload_mode(ctrl_q.reload), .ext_en(ctrl_q.ext_en), .dn_en(ctrl_q.dn_en),
        .ext_lvl(ext_lvl), .ext_fall(ext_fall),
        .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
        .wr_cap_lo(wr_cap_lo), .wr_cap_hi(wr_cap_hi),
        .wdata(reg_wdata),
        .cnt_q(cnt_q), .cap_q(cap_q),
        .tf_set(tf_set), .exf_set(exf_set), .exf_tog(exf_tog));

    // Flag value after a possible software write, before hardware events.
    always_comb exf_base = wr_ctrl ? wr_ctrl_v.exf : ctrl_q.exf;

    // Control register: software fields, sticky flags where hardware wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run     <= wr_ctrl_v.run;
                ctrl_q.src_pin <= wr_ctrl_v.src_pin;
                ctrl_q.reload  <= wr_ctrl_v.reload;
                ctrl_q.ext_en  <= wr_ctrl_v.ext_en;
                ctrl_q.dn_en   <= wr_ctrl_v.dn_en;
            end
            ctrl_q.rsv <= 1'b0;
            ctrl_q.tf  <= tf_set | (wr_ctrl ? wr_ctrl_v.tf : ctrl_q.tf);
            ctrl_q.exf <= exf_set | (exf_tog ? ~exf_base : exf_base);
        end
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = ctrl_q;
            RA_CNT_LO: reg_rdata = cnt_q[BYTE_W-1:0];
            RA_CNT_HI: reg_rdata = cnt_q[CNT_W-1:BYTE_W];
            RA_CAP_LO: reg_rdata = cap_q[BYTE_W-1:0];
            RA_CAP_HI: reg_rdata = cap_q[CNT_W-1:BYTE_W];
            default:   reg_rdata = '0;
        endcase
    end

    // Combined interrupt request; EXF is silent in up/down operation.
    always_comb irq = ctrl_q.tf | (ctrl_q.exf & ~updown);

    // R10
    tf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.tf && !wr_ctrl) |=> ctrl_q.tf);

    // R10
    exf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.exf && !wr_ctrl && !exf_tog) |=> ctrl_q.exf);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_q.tf || ctrl_q.exf));
endmodule

// File: tb/tmr16_capreload_test.sv
`timescale 1ns/1ps
module tmr16_capreload_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       ext_pin = 1'b1;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    tmr16_capreload uut (
        .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .ext_pin(ext_pin),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic set16(input logic [2:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a + 3'd1, v[15:8]);
    endtask

    task automatic pulse_cnt();
        @(negedge clk) cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
        cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_ext();
        @(negedge clk) ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: an expired run is one failed check, then the summary.
    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, exp, cap;
        logic [7:0]  b;
        int          wraps;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state of every register and irq
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), b);
            chk("R1 reg", {8'h00, b}, 16'h0000);
        end
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R3: stopped counter ignores pin edges (src pin, run 0)
        wr(3'd0, 8'h02);
        repeat (3) pulse_cnt();
        rd16(3'd1, v);
        chk("R3 stopped", v, 16'h0000);

        // R2/R12: one count per falling edge, swept
        wr(3'd0, 8'h03);
        for (int i = 1; i <= 20; i++) begin
            pulse_cnt();
            rd16(3'd1, v);
            chk("R2 pin count", v, 16'(i));
        end
        // R12: a rising edge alone does not count
        @(negedge clk) cnt_pin = 1'b0;
        wr(3'd0, 8'h02);
        cnt_pin = 1'b1;
        wr(3'd0, 8'h03);
        repeat (6) @(negedge clk);
        rd16(3'd1, v);
        chk("R12 rise ignored", v, 16'd20);

        // R2: prescaled tick, 60 clocks -> about 10 counts
        wr(3'd0, 8'h00);
        set16(3'd1, 16'h0000);
        wr(3'd0, 8'h01);
        repeat (59) @(negedge clk);
        wr(3'd0, 8'h00);
        rd16(3'd1, v);
        total++;
        if (v < 16'd9 || v > 16'd11) begin
            bad++;
            $display("FAIL R2 prescale got=%0d exp=10", v);
        end

        // R4: capture, continue counting, overwrite
        wr(3'd0, 8'h0B);
        set16(3'd1, 16'h1230);
        repeat (4) pulse_cnt();
        pulse_ext();
        rd16(3'd3, v);
        chk("R4 capture", v, 16'h1234);
        rd(3'd0, b);
        chk("R4 exf", {15'd0, b[6]}, 16'd1);
        chk("R9 irq exf", {15'd0, irq}, 16'd1);
        repeat (2) pulse_cnt();
        rd16(3'd1, v);
        chk("R4 no reload", v, 16'h1236);
        pulse_ext();
        rd16(3'd3, v);
        chk("R4 overwrite", v, 16'h1236);
        // R10: flag holds until written
        repeat (20) @(negedge clk);
        rd(3'd0, b);
        chk("R10 exf held", {15'd0, b[6]}, 16'd1);
        wr(3'd0, 8'h0B);
        rd(3'd0, b);
        chk("R10 cleared", {8'h00, b}, 16'h000B);
        chk("R10 irq low", {15'd0, irq}, 16'd0);

        // R5: capture mode wrap
        set16(3'd1, 16'hFFFE);
        repeat (2) pulse_cnt();
        rd16(3'd1, v);
        chk("R5 wrap", v, 16'h0000);
        rd(3'd0, b);
        chk("R5 tf", {15'd0, b[7]}, 16'd1);
        chk("R9 irq tf", {15'd0, irq}, 16'd1);
        rd16(3'd3, v);
        chk("R5 cap kept", v, 16'h1236);

        // R6: auto-reload up sweep
        wr(3'd0, 8'h07);
        cap = 16'hFFF0;
        set16(3'd3, cap);
        set16(3'd1, 16'hFFF8);
        exp = 16'hFFF8;
        for (int i = 0; i < 40; i++) begin
            pulse_cnt();
            exp = (exp == 16'hFFFF) ? cap : exp + 16'd1;
            rd16(3'd1, v);
            chk("R6 reload up", v, exp);
        end
        rd(3'd0, b);
        chk("R6 tf", {15'd0, b[7]}, 16'd1);

        // R7: external reload, also with run clear
        wr(3'd0, 8'h0E);
        set16(3'd1, 16'h0005);
        pulse_ext();
        rd16(3'd1, v);
        chk("R7 ext reload", v, cap);
        rd(3'd0, b);
        chk("R7 exf", {15'd0, b[6]}, 16'd1);

        // R8: up/down sweep, ext low = down
        wr(3'd0, 8'h17);
        cap = 16'h0003;
        set16(3'd3, cap);
        set16(3'd1, 16'h0008);
        @(negedge clk) ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        exp = 16'h0008;
        wraps = 0;
        for (int i = 0; i < 14; i++) begin
            pulse_cnt();
            if (exp == cap) begin exp = 16'hFFFF; wraps++; end
            else exp = exp - 16'd1;
            rd16(3'd1, v);
            chk("R8 down", v, exp);
        end
        rd(3'd0, b);
        chk("R8 tf", {15'd0, b[7]}, 16'd1);
        chk("R8 exf parity", {15'd0, b[6]}, 16'(wraps % 2));
        // R9: EXF set but silent in up/down operation
        wr(3'd0, 8'h57);
        chk("R9 exf silent", {15'd0, irq}, 16'd0);
        wr(3'd0, 8'h4B);
        chk("R9 exf capture", {15'd0, irq}, 16'd1);
        // R8: ext high = up, reload on top
        wr(3'd0, 8'h17);
        @(negedge clk) ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        set16(3'd1, 16'hFFFE);
        exp = 16'hFFFE;
        for (int i = 0; i < 3; i++) begin
            pulse_cnt();
            exp = (exp == 16'hFFFF) ? cap : exp + 16'd1;
            rd16(3'd1, v);
            chk("R8 up", v, exp);
        end
        rd(3'd0, b);
        chk("R8 exf toggled", {15'd0, b[6]}, 16'd1);
        // R8: ext edge ignored in up/down even with ext enable
        wr(3'd0, 8'h1F);
        pulse_ext();
        rd16(3'd1, v);
        chk("R8 no reload", v, 16'h0004);
        rd16(3'd3, v);
        chk("R8 no capture", v, cap);
        rd(3'd0, b);
        chk("R8 exf unchanged", {8'h00, b}, 16'h001F);

        // R11: byte write collides with a count step
        wr(3'd0, 8'h03);
        set16(3'd1, 16'h0100);
        @(negedge clk) cnt_pin = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_addr = 3'd1; reg_wdata = 8'h55; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd16(3'd1, v);
        chk("R11 write wins", v, 16'h0155);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule